// File: doc/BRIEF.md
# Configuration Command Engine

This block gives software a small three-register window for reaching configuration items on a board: oscillator frequency settings, a supply-level monitor, and the power-off and restart actions. Software first places an operand in the data register if the command needs one. It then writes a packed command word into the command register with the go bit set. The engine decodes the word, runs the operation against its local item table and reports the result in a two-bit status register. The complete flag in that register stays set until software rewrites it.

The command runs in the same clock edge that accepts the command-register write. It has no busy phase, so status, data and any item update can be seen from the following cycle. Power-off and restart commands each produce a one-cycle request pulse on a dedicated output. The main board holds a parameterised bank of oscillator registers with fixed reset values. The supply monitor reports a constant level.

Top module: `cfg_xact_engine`

## Requirements
- R1: After reset the data, command and status registers read 0, both request outputs are 0, and register index 3 always reads 0 and ignores writes. Register indices: 0 data, 1 command, 2 status.
- R2: The command register reads back the written word with bit 31 (go) and bits 19:18 forced to 0. Bits 19:18 have no effect on the decoded command.
- R3: Writing the command register with bit 31 clear changes neither status nor data.
- R4: Writing the command register with bit 31 set runs the command. On success the status becomes 1 (bit 0 complete, bit 1 error clear).
- R5: Command word fields: bit 30 direction (1 store, 0 fetch), bits 29:26 bridge, bits 25:20 function, bits 17:16 site, bits 15:12 slot, bits 11:0 device. A command with a nonzero bridge, a nonzero slot, or site 2 or 3 ends with status 3 and leaves data unchanged.
- R6: A fetch of function 1 (oscillator) at site 0 with device below 6 loads data with that oscillator's value. Reset values for devices 0 to 5 are 50000000, 23750000, 24000000, 24000000, 24000000, 24000000.
- R7: A store of function 1 at site 0 writes the current data value into the addressed oscillator. An oscillator device of 6 or more ends with status 3.
- R8: A fetch of function 2 (supply level) at site 0, device 0, loads data with 3300000. A store to it, or any other device, ends with status 3.
- R9: A store of function 8 at site 0, device 0, raises the power-off request, and function 9 raises the restart request. Each request is high for exactly the cycle after the command write and never both at once. Fetches, failed commands and other devices raise nothing.
- R10: Stores of function 7 or function 11 at site 0, device 0, end with status 1 and change no data, oscillator or request output.
- R11: Every command at site 1 ends with status 3.
- R12: A status register write keeps only bits 1:0 of the written value. Any other function code ends with status 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a register write when bus_en is high |
| bus_idx | input | 2 | Register index: 0 data, 1 command, 2 status, 3 unused |
| bus_wdata | input | 32 | Write value |
| bus_rdata | output | 32 | Read value of the indexed register (combinational) |
| shutdown_req | output | 1 | One-cycle power-off request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
Register reads are combinational on the index, so any register value is due in the same half-cycle after the last edge. A command write presented at one falling edge is taken at the next rising edge. Its status, data and oscillator effects therefore appear from the falling edge after that, and the bench reads them there. The request pulses are due in that same half-cycle and must be gone by the next falling edge, so the bench samples them at both points.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_CMD  = 2'd1,
      REG_STAT = 2'd2,
      REG_NONE = 2'd3
   } cfgx_reg_e;

   // command word field positions
   localparam int GO_BIT    = 31;
   localparam int DIR_BIT   = 30;
   localparam int BRG_LSB   = 26;
   localparam int BRG_W     = 4;
   localparam int FN_LSB    = 20;
   localparam int FN_W      = 6;
   localparam int SITE_LSB  = 16;
   localparam int SITE_W    = 2;
   localparam int SLOT_LSB  = 12;
   localparam int SLOT_W    = 4;
   localparam int DEV_W     = 12;

   // bits that never hold state in the command register
   localparam logic [WORD_W-1:0] CMD_KEEP_MASK = ~(32'h8000_0000 | 32'h000C_0000);

   // function codes
   localparam logic [FN_W-1:0] FN_OSC    = 6'd1;
   localparam logic [FN_W-1:0] FN_LEVEL  = 6'd2;
   localparam logic [FN_W-1:0] FN_VIDSEL = 6'd7;
   localparam logic [FN_W-1:0] FN_PWROFF = 6'd8;
   localparam logic [FN_W-1:0] FN_RESTART= 6'd9;
   localparam logic [FN_W-1:0] FN_DISPMD = 6'd11;

   localparam logic [SITE_W-1:0] SITE_MAIN = 2'd0;
   localparam logic [SITE_W-1:0] SITE_AUX  = 2'd1;

   typedef struct packed {
      logic ok;
      logic fetch_osc;
      logic fetch_level;
      logic store_osc;
      logic pwroff;
      logic restart;
   } cfgx_act_t;

   function automatic logic [WORD_W-1:0] osc_reset_value(input int idx);
      if (idx == 0)      return 32'd50000000;
      else if (idx == 1) return 32'd23750000;
      else               return 32'd24000000;
   endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
   import cfgx_pkg::*;
#(
   parameter int NUM_OSC = 6
) (
   input  logic [WORD_W-1:0] cmd_word,
   output cfgx_act_t         act
);

   logic              dir_store;
   logic [BRG_W-1:0]  brg;
   logic [FN_W-1:0]   fn;
   logic [SITE_W-1:0] site;
   logic [SLOT_W-1:0] slot;
   logic [DEV_W-1:0]  dev;
   logic              route_ok;
   logic              on_main;
   logic              dev_zero;
   logic              osc_in_range;

   assign dir_store    = cmd_word[DIR_BIT];
   assign brg          = cmd_word[BRG_LSB +: BRG_W];
   assign fn           = cmd_word[FN_LSB +: FN_W];
   assign site         = cmd_word[SITE_LSB +: SITE_W];
   assign slot         = cmd_word[SLOT_LSB +: SLOT_W];
   assign dev          = cmd_word[DEV_W-1:0];

   assign route_ok     = (brg == '0) && (slot == '0) &&
                         ((site == SITE_MAIN) || (site == SITE_AUX));
   assign on_main      = (site == SITE_MAIN);
   assign dev_zero     = (dev == '0);
   assign osc_in_range = 32'(dev) < 32'(NUM_OSC);

   always_comb begin
      act = '0;
      if (route_ok && on_main) begin
         unique case (fn)
            FN_OSC: begin
               if (osc_in_range) begin
                  act.ok        = 1'b1;
                  act.store_osc = dir_store;
                  act.fetch_osc = !dir_store;
               end
            end
            FN_LEVEL: begin
               if (dev_zero && !dir_store) begin
                  act.ok          = 1'b1;
                  act.fetch_level = 1'b1;
               end
            end
            FN_PWROFF: begin
               if (dev_zero && dir_store) begin
                  act.ok     = 1'b1;
                  act.pwroff = 1'b1;
               end
            end
            FN_RESTART: begin
               if (dev_zero && dir_store) begin
                  act.ok      = 1'b1;
                  act.restart = 1'b1;
               end
            end
            FN_VIDSEL, FN_DISPMD: begin
               act.ok = dev_zero && dir_store;
            end
            default: act = '0;
         endcase
      end
   end

endmodule

// File: rtl/cfgx_osc_bank.sv
module cfgx_osc_bank
   import cfgx_pkg::*;
#(
   parameter int NUM_OSC = 6,
   localparam int IDX_W  = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_val,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_val
);

   logic [WORD_W-1:0] osc_q [NUM_OSC];

   for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
      localparam logic [WORD_W-1:0] RST_VAL = osc_reset_value(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            osc_q[g] <= RST_VAL;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            osc_q[g] <= wr_val;
      end
   end

   always_comb begin
      rd_val = '0;
      for (int i = 0; i < NUM_OSC; i++) begin
         if (rd_idx == IDX_W'(i))
            rd_val = osc_q[i];
      end
   end

endmodule

// File: rtl/cfg_xact_engine.sv
module cfg_xact_engine
   import cfgx_pkg::*;
#(
   parameter int                NUM_OSC     = 6,
   parameter logic [WORD_W-1:0] LEVEL_VALUE = 32'd3300000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [1:0]        bus_idx,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              shutdown_req,
   output logic              reboot_req
);

   localparam int OSC_IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

   if (NUM_OSC < 1 || NUM_OSC > (1 << DEV_W)) begin : g_bad_osc
      $error("NUM_OSC must lie between 1 and the device field range");
   end

   logic [WORD_W-1:0] data_q;
   logic [WORD_W-1:0] cmd_q;
   logic [1:0]        stat_q;
   logic              pwroff_q;
   logic              restart_q;

   logic              wr_data;
   logic              wr_cmd;
   logic              wr_stat;
   logic              cmd_go;
   cfgx_act_t         act;
   logic [OSC_IDX_W-1:0] osc_idx;
   logic [WORD_W-1:0] osc_val;

   assign wr_data = bus_en && bus_wr && (bus_idx == REG_DATA);
   assign wr_cmd  = bus_en && bus_wr && (bus_idx == REG_CMD);
   assign wr_stat = bus_en && bus_wr && (bus_idx == REG_STAT);
   assign cmd_go  = wr_cmd && bus_wdata[GO_BIT];
   assign osc_idx = bus_wdata[OSC_IDX_W-1:0];

   cfgx_decode #(.NUM_OSC(NUM_OSC)) u_decode (
      .cmd_word (bus_wdata),
      .act      (act)
   );

   cfgx_osc_bank #(.NUM_OSC(NUM_OSC)) u_osc (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cmd_go && act.store_osc),
      .wr_idx (osc_idx),
      .wr_val (data_q),
      .rd_idx (osc_idx),
      .rd_val (osc_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         cmd_q     <= '0;
         stat_q    <= '0;
         pwroff_q  <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         pwroff_q  <= cmd_go && act.pwroff;
         restart_q <= cmd_go && act.restart;
         if (wr_data)
            data_q <= bus_wdata;
         else if (cmd_go && act.fetch_osc)
            data_q <= osc_val;
         else if (cmd_go && act.fetch_level)
            data_q <= LEVEL_VALUE;
         if (wr_cmd)
            cmd_q <= bus_wdata & CMD_KEEP_MASK;
         if (wr_stat)
            stat_q <= bus_wdata[1:0];
         else if (cmd_go)
            stat_q <= {!act.ok, 1'b1};
      end
   end

   always_comb begin
      unique case (bus_idx)
         REG_DATA: bus_rdata = data_q;
         REG_CMD:  bus_rdata = cmd_q;
         REG_STAT: bus_rdata = {{(WORD_W-2){1'b0}}, stat_q};
         default:  bus_rdata = '0;
      endcase
   end

   assign shutdown_req = pwroff_q;
   assign reboot_req   = restart_q;

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_en,
   input logic        bus_wr,
   input logic [1:0]  bus_idx,
   input logic [31:0] bus_wdata,
   input logic [31:0] bus_rdata,
   input logic        shutdown_req,
   input logic        reboot_req,
   input logic [1:0]  stat_q
);

   logic go_now;
   assign go_now = bus_en && bus_wr && (bus_idx == 2'd1) && bus_wdata[31];

   AST_CMD_MASKED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idx == 2'd1) |-> (bus_rdata[31] == 1'b0 && bus_rdata[19:18] == 2'b00)); // R2

   AST_IDLE_CMD_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_wr && bus_idx == 2'd1 && !bus_wdata[31]) |=> $stable(stat_q)); // R3

   AST_GO_SETS_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
      go_now |=> stat_q[0]); // R4

   AST_STATUS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idx == 2'd2) |-> (bus_rdata[31:2] == 30'd0)); // R12

   AST_REQ_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_req || reboot_req) |-> $past(go_now)); // R9

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({shutdown_req, reboot_req})); // R9

   AST_REQ_CLEAN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_req || reboot_req) |-> (stat_q == 2'b01)); // R9

   AST_UNUSED_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_idx == 2'd3) |-> (bus_rdata == 32'd0)); // R1

endmodule

bind cfg_xact_engine cfgx_checker u_cfgx_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_en       (bus_en),
   .bus_wr       (bus_wr),
   .bus_idx      (bus_idx),
   .bus_wdata    (bus_wdata),
   .bus_rdata    (bus_rdata),
   .shutdown_req (shutdown_req),
   .reboot_req   (reboot_req),
   .stat_q       (stat_q)
);

// File: tb/cfg_xact_engine_bench.sv
module cfg_xact_engine_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_idx = 2'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic        shutdown_req;
   logic        reboot_req;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   cfg_xact_engine u_cfg_xact_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_en       (bus_en),
      .bus_wr       (bus_wr),
      .bus_idx      (bus_idx),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .shutdown_req (shutdown_req),
      .reboot_req   (reboot_req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] idx, input logic [31:0] val);
      @(negedge clk);
      bus_en = 1'b1; bus_wr = 1'b1; bus_idx = idx; bus_wdata = val;
      @(negedge clk);
      bus_en = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] idx, output logic [31:0] val);
      bus_idx = idx;
      #1;
      val = bus_rdata;
   endtask

   function automatic logic [31:0] cmd(input bit store, input int brg, input int fn,
                                       input int site, input int slot, input int dev);
      return 32'h8000_0000 | (32'(store) << 30) | (32'(brg & 15) << 26) |
             (32'(fn & 63) << 20) | (32'(site & 3) << 16) | (32'(slot & 15) << 12) |
             32'(dev & 12'hFFF);
   endfunction

   task automatic expect_status(input string tag, input logic [31:0] exp);
      logic [31:0] v;
      reg_read(2'd2, v);
      check(tag, v, exp);
   endtask

   task automatic expect_data(input string tag, input logic [31:0] exp);
      logic [31:0] v;
      reg_read(2'd0, v);
      check(tag, v, exp);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      expect_data("R1 data after reset", 32'd0);
      reg_read(2'd1, v); check("R1 command after reset", v, 32'd0);
      expect_status("R1 status after reset", 32'd0);
      check("R1 requests after reset", {30'd0, shutdown_req, reboot_req}, 32'd0);
      reg_write(2'd3, 32'hDEAD_BEEF);
      reg_read(2'd3, v); check("R1 index 3 reads zero", v, 32'd0);
      expect_data("R1 index 3 write leaves data", 32'd0);
   endtask

   task automatic t_osc_reset_values;
      logic [31:0] exp;
      for (int d = 0; d < 6; d++) begin
         exp = (d == 0) ? 32'd50000000 : (d == 1) ? 32'd23750000 : 32'd24000000;
         reg_write(2'd1, cmd(0, 0, 1, 0, 0, d));
         expect_data("R6 oscillator reset value", exp);
         expect_status("R4 fetch completes clean", 32'd1);
      end
   endtask

   task automatic t_osc_store;
      reg_write(2'd0, 32'd12345678);
      reg_write(2'd1, cmd(1, 0, 1, 0, 0, 2));
      expect_status("R7 store completes", 32'd1);
      reg_write(2'd0, 32'd0);
      reg_write(2'd1, cmd(0, 0, 1, 0, 0, 2));
      expect_data("R7 stored oscillator reads back", 32'd12345678);
      reg_write(2'd1, cmd(0, 0, 1, 0, 0, 3));
      expect_data("R7 neighbour oscillator untouched", 32'd24000000);
      reg_write(2'd1, cmd(0, 0, 1, 0, 0, 6));
      expect_status("R7 device 6 errors", 32'd3);
      expect_data("R7 device 6 leaves data", 32'd24000000);
   endtask

   task automatic t_level;
      reg_write(2'd1, cmd(0, 0, 2, 0, 0, 0));
      expect_data("R8 level value", 32'd3300000);
      expect_status("R8 level fetch clean", 32'd1);
      reg_write(2'd1, cmd(1, 0, 2, 0, 0, 0));
      expect_status("R8 level store errors", 32'd3);
      reg_write(2'd1, cmd(0, 0, 2, 0, 0, 1));
      expect_status("R8 level device 1 errors", 32'd3);
   endtask

   task automatic t_routing;
      reg_write(2'd0, 32'hA5A5_0001);
      reg_write(2'd1, cmd(0, 1, 1, 0, 0, 0));
      expect_status("R5 nonzero bridge errors", 32'd3);
      reg_write(2'd1, cmd(0, 0, 1, 0, 1, 0));
      expect_status("R5 nonzero slot errors", 32'd3);
      reg_write(2'd1, cmd(0, 0, 1, 2, 0, 0));
      expect_status("R5 site 2 errors", 32'd3);
      reg_write(2'd1, cmd(0, 0, 1, 3, 0, 0));
      expect_status("R5 site 3 errors", 32'd3);
      expect_data("R5 failed commands leave data", 32'hA5A5_0001);
      reg_write(2'd1, cmd(0, 0, 1, 1, 0, 0));
      expect_status("R11 site 1 oscillator errors", 32'd3);
      reg_write(2'd1, cmd(0, 0, 2, 1, 0, 0));
      expect_status("R11 site 1 level errors", 32'd3);
      expect_data("R11 site 1 leaves data", 32'hA5A5_0001);
   endtask

   task automatic t_cmd_readback;
      logic [31:0] v;
      reg_write(2'd2, 32'd0);
      reg_write(2'd1, 32'h7FFF_FFFF);
      reg_read(2'd1, v); check("R2 masked readback", v, 32'h7FF3_FFFF);
      expect_status("R3 idle command keeps status", 32'd0);
      expect_data("R3 idle command keeps data", 32'hA5A5_0001);
      reg_write(2'd1, cmd(0, 0, 1, 0, 0, 0) | 32'h000C_0000);
      reg_read(2'd1, v); check("R2 go bit reads zero", v, 32'h0010_0000);
      expect_status("R2 bits 19:18 ignored in decode", 32'd1);
      expect_data("R2 command ran", 32'd50000000);
   endtask

   task automatic t_status_reg;
      reg_write(2'd2, 32'hFFFF_FFFE);
      expect_status("R12 status keeps two bits", 32'd2);
      reg_write(2'd1, cmd(1, 0, 3, 0, 0, 0));
      expect_status("R12 unknown function errors", 32'd3);
      reg_write(2'd1, cmd(0, 0, 8, 0, 0, 0));
      expect_status("R9 fetch of power-off errors", 32'd3);
      check("R9 fetch raises nothing", {30'd0, shutdown_req, reboot_req}, 32'd0);
   endtask

   task automatic t_requests;
      reg_write(2'd1, cmd(1, 0, 8, 0, 0, 0));
      check("R9 power-off pulse", {30'd0, shutdown_req, reboot_req}, 32'd2);
      expect_status("R9 power-off clean", 32'd1);
      @(negedge clk);
      check("R9 power-off one cycle", {30'd0, shutdown_req, reboot_req}, 32'd0);
      reg_write(2'd1, cmd(1, 0, 9, 0, 0, 0));
      check("R9 restart pulse", {30'd0, shutdown_req, reboot_req}, 32'd1);
      @(negedge clk);
      check("R9 restart one cycle", {30'd0, shutdown_req, reboot_req}, 32'd0);
      reg_write(2'd1, cmd(1, 0, 8, 0, 0, 1));
      check("R9 wrong device no pulse", {30'd0, shutdown_req, reboot_req}, 32'd0);
      expect_status("R9 wrong device errors", 32'd3);
   endtask

   task automatic t_noop_funcs;
      reg_write(2'd0, 32'h0BAD_F00D);
      reg_write(2'd1, cmd(1, 0, 7, 0, 0, 0));
      check("R10 function 7 no pulse", {30'd0, shutdown_req, reboot_req}, 32'd0);
      expect_status("R10 function 7 clean", 32'd1);
      reg_write(2'd2, 32'd0);
      reg_write(2'd1, cmd(1, 0, 11, 0, 0, 0));
      check("R10 function 11 no pulse", {30'd0, shutdown_req, reboot_req}, 32'd0);
      expect_status("R10 function 11 clean", 32'd1);
      expect_data("R10 data unchanged", 32'h0BAD_F00D);
      reg_write(2'd1, cmd(0, 0, 1, 0, 0, 0));
      expect_data("R10 oscillator unchanged", 32'd50000000);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_osc_reset_values();
      t_osc_store();
      t_level();
      t_routing();
      t_cmd_readback();
      t_status_reg();
      t_requests();
      t_noop_funcs();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

endmodule